// File: doc/BRIEF.md
# Bank-Aware Write-Speed Issue Arbiter

This block sits inside a resistive-memory controller and decides, every cycle, which queued request goes to which bank and, for writes, how fast the write is performed. Three request queues feed it. The read queue has the highest priority. The normal write-back queue comes second. A small eager write-back queue, filled with dirty lines that the cache has cleaned early, comes last. A slow write wears the cells far less than a fast one, but it holds the bank three times as long. The arbiter therefore spends slow writes only where they cost little: when a bank has a single write waiting, when the bank has used up its wear budget, or when the write is an eager one and the bank is otherwise idle.

Each bank has its own busy timer, which is loaded with the latency of the write sent to it. An external per-bank busy input can also hold a bank off. At most one request issues per cycle, and banks are scanned round-robin. When the normal write queue fills, a drain mode lets writes overtake reads until the queue falls back to its low-water mark. The eager queue never triggers a drain.

Top module: `wsa_arbiter`

## Requirements
- R1: After reset, no request issues, all three enqueue ready outputs are high, and drain mode is off.
- R2: Outside drain mode, a bank with a pending read issues that read (op code 0) and no write of either kind to that bank. A read issues with the slow flag low.
- R3: A normal write (op code 1) to a bank that has exactly one pending normal write issues with the slow flag high.
- R4: A normal write to a bank that has two or more pending normal writes issues with the slow flag low, unless that bank's quota-exceeded input is high, in which case the slow flag is high.
- R5: An eager write (op code 2) issues only when its bank has no pending read and no pending normal write, and it always carries the slow flag high.
- R6: A bank that receives a write cannot take another issue until FAST_LAT (60) cycles after a fast write or SLOW_LAT (180) cycles after a slow write, counting from the issue cycle. The next issue can happen exactly at that cycle. A bank whose busy input is high receives no issue.
- R7: Within one queue, the entries for a given bank issue oldest first.
- R8: At most one request issues per cycle. The bank scan starts at the bank after the last bank that issued, and it starts at bank 0 after reset.
- R9: When the normal write queue holds WR_DEPTH (32) entries, its ready output goes low and drain mode starts on the next cycle. During drain, normal writes beat reads to the same bank. Drain ends once the queue holds DRAIN_LO (16) or fewer entries.
- R10: With EG_DEPTH (16) entries held, the eager ready output is low and a push is dropped, while the other queues keep accepting and issuing. A full eager queue never starts a drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quota_i | input | NUM_BANKS | Per-bank wear-quota-exceeded flag |
| bank_busy_i | input | NUM_BANKS | Per-bank external hold-off |
| rd_push_i | input | 1 | Read enqueue strobe |
| rd_bank_i | input | log2(NUM_BANKS) | Read target bank |
| rd_addr_i | input | ADDR_W | Read address |
| rd_ready_o | output | 1 | Read queue can accept |
| wr_push_i | input | 1 | Normal write enqueue strobe |
| wr_bank_i | input | log2(NUM_BANKS) | Normal write target bank |
| wr_addr_i | input | ADDR_W | Normal write address |
| wr_ready_o | output | 1 | Normal write queue can accept |
| eg_push_i | input | 1 | Eager write enqueue strobe |
| eg_bank_i | input | log2(NUM_BANKS) | Eager write target bank |
| eg_addr_i | input | ADDR_W | Eager write address |
| eg_ready_o | output | 1 | Eager queue can accept |
| iss_vld_o | output | 1 | A request issues this cycle |
| iss_bank_o | output | log2(NUM_BANKS) | Bank of the issued request |
| iss_addr_o | output | ADDR_W | Address of the issued request |
| iss_op_o | output | 2 | 0 read, 1 normal write, 2 eager write |
| iss_slow_o | output | 1 | Write is performed slowly |

## Verification
The two functions most likely to fall in the same cycle are drain entry and the read-first rule. Both act on one bank when a read and a full write queue wait on it together. The bench holds a bank busy while it fills the write queue to capacity behind a single read, then releases the bank. It checks that the first issue is a fast write, and that exactly sixteen writes go out before the waiting read finally issues. A second overlap, an enqueue refused by the full eager queue in the same cycle that another queue accepts and issues a read, is judged from the ready outputs and from the issue port.

// File: rtl/wsa_pkg.sv
package wsa_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EAGER = 2'd2
    } wsa_op_e;
endpackage

// File: rtl/wsa_queue.sv
// Age-ordered request store: slot 0 is the oldest, removal compacts.
module wsa_queue #(
    parameter int DEPTH     = 32,
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               push_i,
    input  logic [BANK_W-1:0]                  push_bank_i,
    input  logic [ADDR_W-1:0]                  push_addr_i,
    output logic                               ready_o,
    input  logic                               pop_i,
    input  logic [BANK_W-1:0]                  pop_bank_i,
    output logic [CNT_W-1:0]                   count_o,
    output logic [NUM_BANKS-1:0]               has_o,
    output logic [NUM_BANKS-1:0]               multi_o,
    output logic [NUM_BANKS-1:0][ADDR_W-1:0]   head_addr_o
);
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0]  ent;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_BANKS-1:0][IDX_W-1:0] head_idx;
    logic [IDX_W-1:0]                pop_idx;
    logic [IDX_W-1:0]                ins_idx;
    logic                            pop_ok;

    assign ready_o = st_q.cnt < CNT_W'(DEPTH);
    assign count_o = st_q.cnt;

    // Per-bank summary: scanning from the youngest slot leaves the oldest.
    always_comb begin : scan_p
        has_o       = '0;
        multi_o     = '0;
        head_addr_o = '0;
        head_idx    = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (CNT_W'(i) < st_q.cnt) begin
                if (has_o[st_q.ent[i].bank]) begin
                    multi_o[st_q.ent[i].bank] = 1'b1;
                end
                has_o[st_q.ent[i].bank]       = 1'b1;
                head_addr_o[st_q.ent[i].bank] = st_q.ent[i].addr;
                head_idx[st_q.ent[i].bank]    = IDX_W'(i);
            end
        end
    end

    always_comb begin : next_p
        st_d    = st_q;
        pop_ok  = pop_i && has_o[pop_bank_i];
        pop_idx = head_idx[pop_bank_i];
        if (pop_ok) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pop_idx) begin
                    st_d.ent[i] = st_q.ent[i+1];
                end
            end
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        ins_idx = st_d.cnt[IDX_W-1:0];
        if (push_i && ready_o) begin
            st_d.ent[ins_idx].bank = push_bank_i;
            st_d.ent[ins_idx].addr = push_addr_i;
            st_d.cnt               = st_d.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wsa_bank_timer.sv
// Occupancy timer for one bank: idle once the count has run down to zero.
module wsa_bank_timer #(
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LAT_W-1:0] lat_i,
    output logic             idle_o
);
    typedef struct packed {
        logic [LAT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    assign idle_o = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            // The issue cycle itself is the first busy cycle.
            st_d.cnt = lat_i - LAT_W'(1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - LAT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wsa_arbiter.sv
module wsa_arbiter
    import wsa_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 16,
    parameter int RD_DEPTH  = 32,
    parameter int WR_DEPTH  = 32,
    parameter int EG_DEPTH  = 16,
    parameter int FAST_LAT  = 60,
    parameter int SLOW_LAT  = 180,
    parameter int DRAIN_LO  = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int WCNT_W   = $clog2(WR_DEPTH + 1),
    localparam int RCNT_W   = $clog2(RD_DEPTH + 1),
    localparam int ECNT_W   = $clog2(EG_DEPTH + 1),
    localparam int LAT_W    = $clog2(SLOW_LAT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] quota_i,
    input  logic [NUM_BANKS-1:0] bank_busy_i,
    input  logic                 rd_push_i,
    input  logic [BANK_W-1:0]    rd_bank_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic                 rd_ready_o,
    input  logic                 wr_push_i,
    input  logic [BANK_W-1:0]    wr_bank_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    output logic                 wr_ready_o,
    input  logic                 eg_push_i,
    input  logic [BANK_W-1:0]    eg_bank_i,
    input  logic [ADDR_W-1:0]    eg_addr_i,
    output logic                 eg_ready_o,
    output logic                 iss_vld_o,
    output logic [BANK_W-1:0]    iss_bank_o,
    output logic [ADDR_W-1:0]    iss_addr_o,
    output logic [1:0]           iss_op_o,
    output logic                 iss_slow_o
);
    typedef struct packed {
        logic              drain;
        logic [BANK_W-1:0] rr;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_BANKS-1:0]             rd_has, wr_has, eg_has;
    logic [NUM_BANKS-1:0]             rd_multi, wr_multi, eg_multi;
    logic [NUM_BANKS-1:0][ADDR_W-1:0] rd_head, wr_head, eg_head;
    logic [RCNT_W-1:0]                rd_cnt;
    logic [WCNT_W-1:0]                wr_cnt;
    logic [ECNT_W-1:0]                eg_cnt;
    logic [NUM_BANKS-1:0]             tmr_idle;

    logic [NUM_BANKS-1:0] cand_vld, cand_slow;
    wsa_op_e              cand_op [NUM_BANKS];
    logic                 iss_vld, iss_slow;
    wsa_op_e              iss_op;
    logic [BANK_W-1:0]    sel, scan_idx;

    wsa_queue #(.DEPTH(RD_DEPTH), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_rdq (
        .clk(clk), .rst_n(rst_n),
        .push_i(rd_push_i), .push_bank_i(rd_bank_i), .push_addr_i(rd_addr_i),
        .ready_o(rd_ready_o),
        .pop_i(iss_vld && iss_op == OP_READ), .pop_bank_i(sel),
        .count_o(rd_cnt), .has_o(rd_has), .multi_o(rd_multi), .head_addr_o(rd_head)
    );

    wsa_queue #(.DEPTH(WR_DEPTH), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_wrq (
        .clk(clk), .rst_n(rst_n),
        .push_i(wr_push_i), .push_bank_i(wr_bank_i), .push_addr_i(wr_addr_i),
        .ready_o(wr_ready_o),
        .pop_i(iss_vld && iss_op == OP_WRITE), .pop_bank_i(sel),
        .count_o(wr_cnt), .has_o(wr_has), .multi_o(wr_multi), .head_addr_o(wr_head)
    );

    wsa_queue #(.DEPTH(EG_DEPTH), .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_egq (
        .clk(clk), .rst_n(rst_n),
        .push_i(eg_push_i), .push_bank_i(eg_bank_i), .push_addr_i(eg_addr_i),
        .ready_o(eg_ready_o),
        .pop_i(iss_vld && iss_op == OP_EAGER), .pop_bank_i(sel),
        .count_o(eg_cnt), .has_o(eg_has), .multi_o(eg_multi), .head_addr_o(eg_head)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_tmr
        wsa_bank_timer #(.LAT_W(LAT_W)) i_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (iss_vld && sel == BANK_W'(b) && iss_op != OP_READ),
            .lat_i  (iss_slow ? LAT_W'(SLOW_LAT) : LAT_W'(FAST_LAT)),
            .idle_o (tmr_idle[b])
        );
    end

    always_comb begin : pick_p
        // Per-bank candidate, in priority order.
        for (int b = 0; b < NUM_BANKS; b++) begin
            cand_vld[b]  = 1'b0;
            cand_slow[b] = 1'b0;
            cand_op[b]   = OP_READ;
            if (tmr_idle[b] && !bank_busy_i[b]) begin
                if (st_q.drain && wr_has[b]) begin
                    cand_vld[b]  = 1'b1;
                    cand_op[b]   = OP_WRITE;
                    cand_slow[b] = !wr_multi[b] || quota_i[b];
                end else if (rd_has[b]) begin
                    cand_vld[b]  = 1'b1;
                    cand_op[b]   = OP_READ;
                end else if (wr_has[b]) begin
                    cand_vld[b]  = 1'b1;
                    cand_op[b]   = OP_WRITE;
                    cand_slow[b] = !wr_multi[b] || quota_i[b];
                end else if (eg_has[b]) begin
                    cand_vld[b]  = 1'b1;
                    cand_op[b]   = OP_EAGER;
                    cand_slow[b] = 1'b1;
                end
            end
        end

        // Round-robin scan from the bank after the last winner.
        iss_vld  = 1'b0;
        sel      = '0;
        scan_idx = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            scan_idx = st_q.rr + BANK_W'(k);
            if (!iss_vld && cand_vld[scan_idx]) begin
                iss_vld = 1'b1;
                sel     = scan_idx;
            end
        end
        iss_op   = cand_op[sel];
        iss_slow = iss_vld && cand_slow[sel];

        st_d = st_q;
        if (iss_vld) begin
            st_d.rr = sel + BANK_W'(1);
        end
        st_d.drain = st_q.drain ? (wr_cnt > WCNT_W'(DRAIN_LO))
                                : (wr_cnt == WCNT_W'(WR_DEPTH));
    end

    always_comb begin : addr_p
        case (iss_op)
            OP_WRITE: iss_addr_o = wr_head[sel];
            OP_EAGER: iss_addr_o = eg_head[sel];
            default:  iss_addr_o = rd_head[sel];
        endcase
    end

    assign iss_vld_o  = iss_vld;
    assign iss_bank_o = sel;
    assign iss_op_o   = iss_op;
    assign iss_slow_o = iss_slow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wsa_arbiter_chk.sv
module wsa_arbiter_chk
    import wsa_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int WR_DEPTH  = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int WCNT_W   = $clog2(WR_DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] bank_busy_i,
    input logic                 iss_vld_o,
    input logic [BANK_W-1:0]    iss_bank_o,
    input logic [1:0]           iss_op_o,
    input logic                 iss_slow_o,
    input logic [NUM_BANKS-1:0] rd_has,
    input logic [NUM_BANKS-1:0] wr_has,
    input logic [NUM_BANKS-1:0] tmr_idle,
    input logic                 drain,
    input logic [WCNT_W-1:0]    wr_cnt
);
    // R2
    no_wr_over_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld_o && iss_op_o != OP_READ && !drain |-> !rd_has[iss_bank_o]);

    // R2
    read_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld_o && iss_op_o == OP_READ |-> !iss_slow_o);

    // R5
    eager_slow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld_o && iss_op_o == OP_EAGER |->
            iss_slow_o && !wr_has[iss_bank_o] && !rd_has[iss_bank_o]);

    // R6
    idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld_o |-> tmr_idle[iss_bank_o] && !bank_busy_i[iss_bank_o]);

    // R6
    busy_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld_o && iss_op_o != OP_READ |=> !tmr_idle[$past(iss_bank_o)]);

    // R9
    drain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt == WCNT_W'(WR_DEPTH) |=> drain);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= WCNT_W'(WR_DEPTH));
endmodule

bind wsa_arbiter wsa_arbiter_chk #(.NUM_BANKS(NUM_BANKS), .WR_DEPTH(WR_DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .bank_busy_i(bank_busy_i),
    .iss_vld_o(iss_vld_o), .iss_bank_o(iss_bank_o), .iss_op_o(iss_op_o),
    .iss_slow_o(iss_slow_o), .rd_has(rd_has), .wr_has(wr_has),
    .tmr_idle(tmr_idle), .drain(st_q.drain), .wr_cnt(wr_cnt)
);

// File: tb/test_wsa_arbiter.sv
module test_wsa_arbiter;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NB = 4;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] quota_i = '0, bank_busy_i = '0;
    logic          rd_push_i = 1'b0, wr_push_i = 1'b0, eg_push_i = 1'b0;
    logic [1:0]    rd_bank_i = '0, wr_bank_i = '0, eg_bank_i = '0;
    logic [AW-1:0] rd_addr_i = '0, wr_addr_i = '0, eg_addr_i = '0;
    logic          rd_ready_o, wr_ready_o, eg_ready_o;
    logic          iss_vld_o, iss_slow_o;
    logic [1:0]    iss_bank_o, iss_op_o;
    logic [AW-1:0] iss_addr_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    wsa_arbiter i_wsa_arbiter (
        .clk(clk), .rst_n(rst_n), .quota_i(quota_i), .bank_busy_i(bank_busy_i),
        .rd_push_i(rd_push_i), .rd_bank_i(rd_bank_i), .rd_addr_i(rd_addr_i), .rd_ready_o(rd_ready_o),
        .wr_push_i(wr_push_i), .wr_bank_i(wr_bank_i), .wr_addr_i(wr_addr_i), .wr_ready_o(wr_ready_o),
        .eg_push_i(eg_push_i), .eg_bank_i(eg_bank_i), .eg_addr_i(eg_addr_i), .eg_ready_o(eg_ready_o),
        .iss_vld_o(iss_vld_o), .iss_bank_o(iss_bank_o), .iss_addr_o(iss_addr_o),
        .iss_op_o(iss_op_o), .iss_slow_o(iss_slow_o)
    );

    // {reads, normal writes, eager writes, quota, expected op, expected slow}
    localparam int NV = 10;
    localparam logic [9:0] VECS [NV] = '{
        {2'd1, 2'd0, 2'd0, 1'b0, 2'd0, 1'b0},  // R2 lone read
        {2'd0, 2'd1, 2'd0, 1'b0, 2'd1, 1'b1},  // R3 single write slow
        {2'd0, 2'd2, 2'd0, 1'b0, 2'd1, 1'b0},  // R4 two writes fast
        {2'd0, 2'd2, 2'd0, 1'b1, 2'd1, 1'b1},  // R4 quota forces slow
        {2'd1, 2'd2, 2'd0, 1'b0, 2'd0, 1'b0},  // R2 read beats writes
        {2'd0, 2'd0, 2'd1, 1'b0, 2'd2, 1'b1},  // R5 eager alone
        {2'd0, 2'd1, 2'd1, 1'b0, 2'd1, 1'b1},  // R5 eager waits for write
        {2'd1, 2'd0, 2'd1, 1'b0, 2'd0, 1'b0},  // R5 eager waits for read
        {2'd0, 2'd3, 2'd0, 1'b0, 2'd1, 1'b0},  // R4 three writes fast
        {2'd0, 2'd1, 2'd0, 1'b1, 2'd1, 1'b1}   // R3 single write with quota
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        quota_i = '0; bank_busy_i = '0;
        rd_push_i = 1'b0; wr_push_i = 1'b0; eg_push_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push_rd(input logic [1:0] b, input logic [AW-1:0] a);
        @(negedge clk);
        rd_push_i = 1'b1; rd_bank_i = b; rd_addr_i = a;
        @(negedge clk);
        rd_push_i = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int k, nw, ne;
        logic bad;

        // R1 reset state
        do_reset();
        chk("R1 no issue", iss_vld_o, 0);
        chk("R1 rd ready", rd_ready_o, 1);
        chk("R1 wr ready", wr_ready_o, 1);
        chk("R1 eg ready", eg_ready_o, 1);

        // Table walk: load one bank while held busy, release, judge first issue.
        for (int v = 0; v < NV; v++) begin
            logic [1:0] vb, nrd, nwr, neg, eop;
            logic       q, eslow;
            logic [AW-1:0] eaddr;
            {nrd, nwr, neg, q, eop, eslow} = VECS[v];
            vb = 2'(v % NB);
            do_reset();
            bank_busy_i = '1;
            quota_i = q ? (NB'(1) << vb) : '0;
            for (int n = 0; n < 3; n++) begin
                @(negedge clk);
                rd_push_i = (n < nrd); rd_bank_i = vb; rd_addr_i = AW'(16'h100 + n);
                wr_push_i = (n < nwr); wr_bank_i = vb; wr_addr_i = AW'(16'h200 + n);
                eg_push_i = (n < neg); eg_bank_i = vb; eg_addr_i = AW'(16'h300 + n);
            end
            @(negedge clk);
            rd_push_i = 1'b0; wr_push_i = 1'b0; eg_push_i = 1'b0;
            chk("R6 busy input holds bank", iss_vld_o, 0);
            bank_busy_i[vb] = 1'b0;
            #1;
            eaddr = (eop == 2'd0) ? 16'h100 : (eop == 2'd1) ? 16'h200 : 16'h300;
            chk("R2/R3/R4/R5 vector issue", iss_vld_o, 1);
            chk("R2/R3/R4/R5 vector bank", iss_bank_o, vb);
            chk("R2/R3/R4/R5 vector op", iss_op_o, eop);
            chk("R3/R4/R5 vector slow flag", iss_slow_o, eslow);
            chk("R7 vector oldest addr", iss_addr_o, eaddr);
        end

        // R6 slow spacing: lone write slow, next lone write exactly SLOW_LAT later
        do_reset();
        @(negedge clk);
        wr_push_i = 1'b1; wr_bank_i = 2'd0; wr_addr_i = 16'hA0;
        @(negedge clk);
        chk("R3 lone write slow", iss_slow_o, 1);
        chk("R3 lone write issued", iss_vld_o, 1);
        wr_addr_i = 16'hA1;
        k = 0;
        do begin
            @(negedge clk);
            wr_push_i = 1'b0;
            k++;
        end while (!iss_vld_o && k < 1000);
        chk("R6 slow write occupancy", k, 180);
        chk("R6 second write addr", iss_addr_o, 16'hA1);

        // R6 fast spacing
        do_reset();
        bank_busy_i[0] = 1'b1;
        @(negedge clk);
        wr_push_i = 1'b1; wr_bank_i = 2'd0; wr_addr_i = 16'hC0;
        @(negedge clk);
        wr_addr_i = 16'hC1;
        @(negedge clk);
        wr_push_i = 1'b0;
        bank_busy_i = '0;
        #1;
        chk("R4 first of two fast", iss_slow_o, 0);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!iss_vld_o && k < 1000);
        chk("R6 fast write occupancy", k, 60);
        chk("R3 remaining single write slow", iss_slow_o, 1);

        // R7 and R8: per-bank age order, round-robin scan
        do_reset();
        bank_busy_i = '1;
        push_rd(2'd1, 16'h11);
        push_rd(2'd2, 16'h99);
        push_rd(2'd1, 16'h22);
        bank_busy_i = '0;
        #1;
        chk("R8 scan from bank0 finds bank1", iss_bank_o, 1);
        chk("R7 oldest bank1 read first", iss_addr_o, 16'h11);
        @(negedge clk);
        chk("R8 next bank2", iss_bank_o, 2);
        chk("R8 one issue per cycle", iss_vld_o, 1);
        @(negedge clk);
        chk("R7 younger bank1 read", iss_addr_o, 16'h22);
        @(negedge clk);
        bank_busy_i = '1;
        push_rd(2'd0, 16'h40);
        push_rd(2'd3, 16'h43);
        bank_busy_i = '0;
        #1;
        chk("R8 pointer after bank1 prefers bank3", iss_bank_o, 3);
        @(negedge clk);
        chk("R8 wrap to bank0", iss_bank_o, 0);

        // R9 drain: full write queue behind one read
        do_reset();
        bank_busy_i[0] = 1'b1;
        for (int n = 0; n < 32; n++) begin
            @(negedge clk);
            rd_push_i = (n == 0); rd_bank_i = 2'd0; rd_addr_i = 16'h77;
            wr_push_i = 1'b1; wr_bank_i = 2'd0; wr_addr_i = AW'(16'h500 + n);
        end
        @(negedge clk);
        rd_push_i = 1'b0; wr_push_i = 1'b0;
        chk("R9 full write queue not ready", wr_ready_o, 0);
        @(negedge clk);
        bank_busy_i = '0;
        #1;
        chk("R9 drain write beats read", iss_op_o, 1);
        chk("R9 drain write fast", iss_slow_o, 0);
        chk("R9 drain write oldest", iss_addr_o, 16'h500);
        nw = 1;
        k = 0;
        bad = 1'b0;
        while (k < 3000) begin
            @(negedge clk);
            k++;
            if (iss_vld_o) begin
                if (iss_op_o == 2'd1) nw++;
                else begin
                    bad = (iss_addr_o != 16'h77);
                    break;
                end
            end
        end
        chk("R9 writes before drain ends", nw, 16);
        chk("R9 read after drain", bad, 0);
        chk("R9 write queue ready again", wr_ready_o, 1);

        // R10 eager queue full
        do_reset();
        bank_busy_i[3] = 1'b1;
        for (int n = 0; n < 16; n++) begin
            @(negedge clk);
            eg_push_i = 1'b1; eg_bank_i = 2'd3; eg_addr_i = AW'(16'h600 + n);
        end
        @(negedge clk);
        chk("R10 eager full not ready", eg_ready_o, 0);
        eg_addr_i = 16'h6FF;
        rd_push_i = 1'b1; rd_bank_i = 2'd1; rd_addr_i = 16'h31;
        @(negedge clk);
        eg_push_i = 1'b0; rd_push_i = 1'b0;
        chk("R10 read accepted beside full eager", iss_op_o, 0);
        chk("R10 read issues beside full eager", iss_addr_o, 16'h31);
        chk("R10 no drain from eager", wr_ready_o, 1);
        @(negedge clk);
        bank_busy_i = '0;
        #1;
        ne = 0;
        bad = 1'b0;
        for (int c = 0; c < 16 * 180 + 100; c++) begin
            if (iss_vld_o && iss_op_o == 2'd2) begin
                ne++;
                if (iss_addr_o == 16'h6FF) bad = 1'b1;
                if (!iss_slow_o) bad = 1'b1;
            end
            @(negedge clk);
            #1;
        end
        chk("R10 eager issue count", ne, 16);
        chk("R10 refused entry absent, R5 all slow", bad, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule